// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block sits next to a simple processor core and decides, every clock, whether the core takes an exception and which one. It watches seven request inputs: a reset request, an undefined-instruction flag, a software-interrupt flag, a prefetch-abort flag, a data-abort flag, and the normal and fast interrupt lines. When one of them wins, the block saves the current status word in the saved-status register of the mode that will run the handler. It also saves the return address in that mode's banked link register, switches the mode field, sets the interrupt mask bits and redirects the program counter to a fixed low-memory vector.

The core uses the same block to leave a handler. A return request restores the status word from the current mode's saved-status register and redirects the program counter to that mode's saved link address. A status-write port lets handler code clear the mask bits. This is how a running normal-interrupt handler lets a fast interrupt preempt it. Every output is registered, so a request seen at one clock edge is reflected on the outputs right after that edge.

Top module: `exc_entry_seq`

## Requirements
- R1: On a taken exception `pc_load` pulses for one cycle and `pc_target` equals the exception code times four. The codes are reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, normal interrupt 6 and fast interrupt 7. Address 0x14 is never produced, and `pc_target` holds its value between loads.
- R2: When several requests are live in one cycle, the winner is chosen in this order: reset, data abort, unmasked fast interrupt, unmasked normal interrupt, prefetch abort, undefined, software interrupt. `exc_taken` pulses for one cycle with the winner on `exc_code`.
- R3: On every entry other than reset, the status word held just before entry is stored in the saved-status register of the target mode.
- R4: Mode field `status[4:0]` changes to the target mode. Undefined goes to 0x1B. Software interrupt and reset go to 0x13. Both aborts go to 0x17. The normal interrupt goes to 0x12 and the fast interrupt to 0x11. User mode is 0x10.
- R5: Every entry sets the normal-interrupt mask `status[7]`. Fast-interrupt and reset entries also set the fast-interrupt mask `status[6]`. Otherwise `status[6]` is kept.
- R6: A normal-interrupt request while `status[7]` is 1, or a fast-interrupt request while `status[6]` is 1, is ignored.
- R7: A reset request loads status 0x000000D3 and vector 0. It writes no saved-status register and no link register.
- R8: On entry, the target mode's link register gets `cur_pc` plus 8 for a data abort and plus 4 for every other exception.
- R9: A return request with no winning exception, in a mode that has a bank (0x11, 0x12, 0x13, 0x17, 0x1B), restores status from that bank and loads `pc_target` from its link register with a `pc_load` pulse. In any other mode it is ignored.
- R10: `sr_we` loads `sr_wdata` into the status word when no exception wins and no return is taken.
- R11: Once a normal-interrupt handler clears `status[7]`, a fast interrupt preempts it. Returning from the fast interrupt and then from the normal interrupt restores each earlier status in turn.
- R12: After `rst_n` is asserted, status is 0x000000D3, and `pc_load`, `exc_taken` and `pc_target` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Reset exception request |
| und_req | input | 1 | Undefined-instruction flag |
| swi_req | input | 1 | Software-interrupt flag |
| pabt_req | input | 1 | Prefetch-abort flag |
| dabt_req | input | 1 | Data-abort flag |
| irq_req | input | 1 | Normal interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| ret_req | input | 1 | Return from handler |
| sr_we | input | 1 | Status word write enable |
| sr_wdata | input | SR_W | Status word write data |
| cur_pc | input | XLEN | Current program counter of the core |
| status | output | SR_W | Current status word |
| pc_load | output | 1 | Program counter redirect strobe |
| pc_target | output | XLEN | Redirect address |
| exc_taken | output | 1 | Exception taken strobe |
| exc_code | output | 3 | Code of the exception taken |

## Verification
A wrong saved-status or link entry stays invisible at entry. It shows up only at the later return from that mode, as a wrong restored `status` or `pc_target` on the cycle after the return request. The bench therefore nests entries and returns, including a reset between an entry and its return. A wrong mask bit or a wrong priority shows up on the very next cycle, as the wrong `exc_code` or as a strobe that should not be there. A wrong mode field shows up at once in `status` and again at the next return, which then reads the wrong bank.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [2:0] {
      EXC_RESET = 3'd0,
      EXC_UND   = 3'd1,
      EXC_SWI   = 3'd2,
      EXC_PABT  = 3'd3,
      EXC_DABT  = 3'd4,
      EXC_IRQ   = 3'd6,
      EXC_FIQ   = 3'd7
   } exc_code_e;

   localparam logic [4:0] MODE_USR = 5'h10;
   localparam logic [4:0] MODE_FIQ = 5'h11;
   localparam logic [4:0] MODE_IRQ = 5'h12;
   localparam logic [4:0] MODE_SVC = 5'h13;
   localparam logic [4:0] MODE_ABT = 5'h17;
   localparam logic [4:0] MODE_UND = 5'h1B;

   localparam int NUM_BANKS = 5;
   localparam int BANK_W    = $clog2(NUM_BANKS);
   localparam int SR_IBIT   = 7;
   localparam int SR_FBIT   = 6;

   typedef struct packed {
      logic              ok;
      logic [BANK_W-1:0] idx;
   } bank_sel_t;

   function automatic logic [4:0] target_mode(input exc_code_e c);
      case (c)
         EXC_UND:            return MODE_UND;
         EXC_PABT, EXC_DABT: return MODE_ABT;
         EXC_IRQ:            return MODE_IRQ;
         EXC_FIQ:            return MODE_FIQ;
         default:            return MODE_SVC;
      endcase
   endfunction

   function automatic logic [3:0] lr_offset(input exc_code_e c);
      return (c == EXC_DABT) ? 4'd8 : 4'd4;
   endfunction

   function automatic bank_sel_t bank_of(input logic [4:0] m);
      bank_sel_t b;
      b.ok = 1'b1;
      case (m)
         MODE_FIQ: b.idx = BANK_W'(0);
         MODE_IRQ: b.idx = BANK_W'(1);
         MODE_SVC: b.idx = BANK_W'(2);
         MODE_ABT: b.idx = BANK_W'(3);
         MODE_UND: b.idx = BANK_W'(4);
         default: begin
            b.ok  = 1'b0;
            b.idx = '0;
         end
      endcase
      return b;
   endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
(
   input  logic      reset_req,
   input  logic      und_req,
   input  logic      swi_req,
   input  logic      pabt_req,
   input  logic      dabt_req,
   input  logic      irq_req,
   input  logic      fiq_req,
   input  logic      irq_masked,
   input  logic      fiq_masked,
   output logic      hit,
   output exc_code_e code
);

   always_comb begin
      hit  = 1'b1;
      code = EXC_RESET;
      if (reset_req)                    code = EXC_RESET;
      else if (dabt_req)                code = EXC_DABT;
      else if (fiq_req && !fiq_masked)  code = EXC_FIQ;
      else if (irq_req && !irq_masked)  code = EXC_IRQ;
      else if (pabt_req)                code = EXC_PABT;
      else if (und_req)                 code = EXC_UND;
      else if (swi_req)                 code = EXC_SWI;
      else                              hit  = 1'b0;
   end

endmodule

// File: rtl/exc_bank.sv
module exc_bank
   import exc_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int SR_W = 32,
   parameter int NB   = NUM_BANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BANK_W-1:0] wr_idx,
   input  logic [SR_W-1:0]   wr_sr,
   input  logic [XLEN-1:0]   wr_lr,
   input  logic [BANK_W-1:0] rd_idx,
   output logic [SR_W-1:0]   rd_sr,
   output logic [XLEN-1:0]   rd_lr
);

   logic [SR_W-1:0] sr_q [NB];
   logic [XLEN-1:0] lr_q [NB];

   for (genvar g = 0; g < NB; g++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr_q[g] <= '0;
            lr_q[g] <= '0;
         end else if (we && wr_idx == BANK_W'(g)) begin
            sr_q[g] <= wr_sr;
            lr_q[g] <= wr_lr;
         end
      end
   end

   always_comb begin
      rd_sr = '0;
      rd_lr = '0;
      for (int i = 0; i < NB; i++) begin
         if (rd_idx == BANK_W'(i)) begin
            rd_sr = sr_q[i];
            rd_lr = lr_q[i];
         end
      end
   end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int SR_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reset_req,
   input  logic            und_req,
   input  logic            swi_req,
   input  logic            pabt_req,
   input  logic            dabt_req,
   input  logic            irq_req,
   input  logic            fiq_req,
   input  logic            ret_req,
   input  logic            sr_we,
   input  logic [SR_W-1:0] sr_wdata,
   input  logic [XLEN-1:0] cur_pc,
   output logic [SR_W-1:0] status,
   output logic            pc_load,
   output logic [XLEN-1:0] pc_target,
   output logic            exc_taken,
   output logic [2:0]      exc_code
);

   localparam logic [SR_W-1:0] SR_RESET = SR_W'({2'b11, 1'b0, MODE_SVC});

   if (SR_W < 8) begin : g_bad_sr
      $error("exc_entry_seq: SR_W must be at least 8");
   end
   if (XLEN < 8) begin : g_bad_xlen
      $error("exc_entry_seq: XLEN must be at least 8");
   end

   logic            hit;
   exc_code_e       win_code;
   logic [4:0]      tgt_mode;
   bank_sel_t       cur_b, tgt_b;
   logic            bank_we, ret_go;
   logic [XLEN-1:0] lr_val;
   logic [SR_W-1:0] sr_entry;
   logic [SR_W-1:0] rd_sr;
   logic [XLEN-1:0] rd_lr;

   exc_arbiter u_arb (
      .reset_req  (reset_req),
      .und_req    (und_req),
      .swi_req    (swi_req),
      .pabt_req   (pabt_req),
      .dabt_req   (dabt_req),
      .irq_req    (irq_req),
      .fiq_req    (fiq_req),
      .irq_masked (status[SR_IBIT]),
      .fiq_masked (status[SR_FBIT]),
      .hit        (hit),
      .code       (win_code)
   );

   always_comb begin
      tgt_mode = target_mode(win_code);
      tgt_b    = bank_of(tgt_mode);
      cur_b    = bank_of(status[4:0]);
      bank_we  = hit && (win_code != EXC_RESET);
      ret_go   = ret_req && !hit && cur_b.ok;
      lr_val   = cur_pc + XLEN'(lr_offset(win_code));
      sr_entry = status;
      sr_entry[4:0]    = tgt_mode;
      sr_entry[SR_IBIT] = 1'b1;
      if (win_code == EXC_FIQ) sr_entry[SR_FBIT] = 1'b1;
      if (win_code == EXC_RESET) sr_entry = SR_RESET;
   end

   exc_bank #(.XLEN(XLEN), .SR_W(SR_W), .NB(NUM_BANKS)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bank_we),
      .wr_idx (tgt_b.idx),
      .wr_sr  (status),
      .wr_lr  (lr_val),
      .rd_idx (cur_b.idx),
      .rd_sr  (rd_sr),
      .rd_lr  (rd_lr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status    <= SR_RESET;
         pc_load   <= 1'b0;
         pc_target <= '0;
         exc_taken <= 1'b0;
         exc_code  <= '0;
      end else begin
         pc_load   <= 1'b0;
         exc_taken <= 1'b0;
         if (hit) begin
            status    <= sr_entry;
            pc_load   <= 1'b1;
            pc_target <= XLEN'({win_code, 2'b00});
            exc_taken <= 1'b1;
            exc_code  <= win_code;
         end else if (ret_go) begin
            status    <= rd_sr;
            pc_load   <= 1'b1;
            pc_target <= rd_lr;
         end else if (sr_we) begin
            status    <= sr_wdata;
         end
      end
   end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int XLEN = 32,
   parameter int SR_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reset_req,
   input logic            und_req,
   input logic            swi_req,
   input logic            pabt_req,
   input logic            dabt_req,
   input logic            irq_req,
   input logic            fiq_req,
   input logic            ret_req,
   input logic            sr_we,
   input logic [SR_W-1:0] sr_wdata,
   input logic [XLEN-1:0] cur_pc,
   input logic [SR_W-1:0] status,
   input logic            pc_load,
   input logic [XLEN-1:0] pc_target,
   input logic            exc_taken,
   input logic [2:0]      exc_code
);

   assert_vec_no_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken |-> (pc_load && pc_target != XLEN'(8'h14)));

   assert_fiq_over_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_req && irq_req && !status[6] && !reset_req && !dabt_req)
      |=> (exc_taken && exc_code == 3'd7));

   assert_entry_imask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken |-> status[7]);

   assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && status[7] && !reset_req && !und_req && !swi_req &&
       !pabt_req && !dabt_req && !fiq_req) |=> !exc_taken);

   assert_reset_svc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> (status == SR_W'(8'hD3) && pc_target == '0));

endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .SR_W(SR_W)) u_chk (.*);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

   localparam int CLK_NS = 20;
   localparam int B_RST = 1, B_UND = 2, B_SWI = 4, B_PABT = 8, B_DABT = 16,
                  B_IRQ = 32, B_FIQ = 64, B_RET = 128, B_WE = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reset_req = 0, und_req = 0, swi_req = 0, pabt_req = 0, dabt_req = 0;
   logic        irq_req = 0, fiq_req = 0, ret_req = 0, sr_we = 0;
   logic [31:0] sr_wdata = '0, cur_pc = '0;
   logic [31:0] status, pc_target;
   logic        pc_load, exc_taken;
   logic [2:0]  exc_code;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   logic [31:0] m_sr [5];
   logic [31:0] m_lr [5];
   logic [31:0] m_status, e_target;

   always #(CLK_NS/2) clk = ~clk;

   exc_entry_seq u_dut (
      .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .und_req(und_req),
      .swi_req(swi_req), .pabt_req(pabt_req), .dabt_req(dabt_req),
      .irq_req(irq_req), .fiq_req(fiq_req), .ret_req(ret_req), .sr_we(sr_we),
      .sr_wdata(sr_wdata), .cur_pc(cur_pc), .status(status), .pc_load(pc_load),
      .pc_target(pc_target), .exc_taken(exc_taken), .exc_code(exc_code)
   );

   function automatic int bidx(input logic [4:0] m);
      case (m)
         5'h11: return 0;
         5'h12: return 1;
         5'h13: return 2;
         5'h17: return 3;
         5'h1B: return 4;
         default: return -1;
      endcase
   endfunction

   function automatic logic [4:0] mode_for(input logic [2:0] c);
      case (c)
         3'd1: return 5'h1B;
         3'd3, 3'd4: return 5'h17;
         3'd6: return 5'h12;
         3'd7: return 5'h11;
         default: return 5'h13;
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, advance the model, compare at next negedge
   task automatic step(input int bits, input logic [31:0] wd,
                       input logic [31:0] pc, input string tag_in);
      logic tk, ld;
      logic [2:0] c;
      int b;
      string tag;
      reset_req = bits[0]; und_req = bits[1]; swi_req = bits[2];
      pabt_req = bits[3]; dabt_req = bits[4]; irq_req = bits[5];
      fiq_req = bits[6]; ret_req = bits[7]; sr_we = bits[8];
      sr_wdata = wd; cur_pc = pc;
      tk = 1'b1; ld = 1'b0; c = 3'd0; tag = tag_in;
      if (bits[0])                        c = 3'd0;
      else if (bits[4])                   c = 3'd4;
      else if (bits[6] && !m_status[6])   c = 3'd7;
      else if (bits[5] && !m_status[7])   c = 3'd6;
      else if (bits[3])                   c = 3'd3;
      else if (bits[1])                   c = 3'd1;
      else if (bits[2])                   c = 3'd2;
      else                                tk = 1'b0;
      if (tk) begin
         ld = 1'b1;
         e_target = {27'd0, c, 2'b00};
         if (c == 3'd0) begin
            m_status = 32'hD3;
            if (tag == "") tag = "R7";
         end else begin
            b = bidx(mode_for(c));
            m_sr[b] = m_status;
            m_lr[b] = pc + ((c == 3'd4) ? 32'd8 : 32'd4);
            m_status = {m_status[31:8], 1'b1, (c == 3'd7) ? 1'b1 : m_status[6],
                        m_status[5], mode_for(c)};
            if (tag == "") tag = "R2";
         end
      end else if (bits[7] && bidx(m_status[4:0]) >= 0) begin
         b = bidx(m_status[4:0]);
         ld = 1'b1;
         e_target = m_lr[b];
         m_status = m_sr[b];
         if (tag == "") tag = "R9";
      end else if (bits[8]) begin
         m_status = wd;
         if (tag == "") tag = "R10";
      end else if (tag == "") tag = "R6";
      @(posedge clk);
      @(negedge clk);
      chk(tag, "status", status, m_status);
      chk("R2", "exc_taken", {31'd0, exc_taken}, {31'd0, tk});
      chk("R1", "pc_load", {31'd0, pc_load}, {31'd0, ld});
      chk("R1", "pc_target", pc_target, e_target);
      if (tk) chk("R2", "exc_code", {29'd0, exc_code}, {29'd0, c});
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
   end

   initial begin
      logic [4:0] modes [6] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
      int r, bits;
      logic [31:0] wd;
      void'($urandom(32'd2024));
      for (int i = 0; i < 5; i++) begin m_sr[i] = '0; m_lr[i] = '0; end
      m_status = 32'hD3;
      e_target = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: state after reset
      chk("R12", "status", status, 32'hD3);
      chk("R12", "pc_load", {31'd0, pc_load}, 32'd0);
      chk("R12", "exc_taken", {31'd0, exc_taken}, 32'd0);
      chk("R12", "pc_target", pc_target, 32'd0);

      step(B_WE, 32'h10, 32'h0, "R10");
      chk("R10", "user status", status, 32'h10);
      step(B_IRQ | B_FIQ, 0, 32'h40, "R2");
      chk("R5", "fiq entry masks", status, 32'hD1);
      chk("R4", "fiq mode", {27'd0, status[4:0]}, 32'h11);
      step(B_RET, 0, 32'h0, "R9");
      chk("R3", "restored", status, 32'h10);
      chk("R8", "fiq link", pc_target, 32'h44);

      // R11: nested preemption
      step(B_IRQ, 0, 32'h100, "R11");
      chk("R5", "irq entry", status, 32'h92);
      step(B_IRQ, 0, 32'h0, "R6");
      step(B_WE, 32'h12, 32'h0, "R11");
      step(B_FIQ, 0, 32'h200, "R11");
      chk("R11", "preempt", status, 32'hD1);
      step(B_RET, 0, 32'h0, "R11");
      chk("R11", "back to irq", status, 32'h12);
      chk("R11", "irq resume pc", pc_target, 32'h204);
      step(B_RET, 0, 32'h0, "R11");
      chk("R11", "back to user", status, 32'h10);
      chk("R8", "irq link", pc_target, 32'h104);

      step(B_DABT | B_PABT, 0, 32'h300, "R2");
      chk("R4", "abort mode", status, 32'h97);
      step(B_RET, 0, 32'h0, "R8");
      chk("R8", "dabt link", pc_target, 32'h308);

      // R7: reset between entry and return leaves the bank intact
      step(B_SWI, 0, 32'h400, "R4");
      chk("R4", "svc mode", status, 32'h93);
      step(B_RST | B_IRQ, 0, 32'h0, "R7");
      chk("R7", "vector", pc_target, 32'h0);
      step(B_RET, 0, 32'h0, "R7");
      chk("R7", "svc bank kept", status, 32'h10);
      chk("R7", "svc link kept", pc_target, 32'h404);
      step(B_RET, 0, 32'h0, "R9");
      chk("R9", "user return ignored", {31'd0, pc_load}, 32'd0);
      step(B_UND, 0, 32'h500, "R4");
      chk("R4", "und mode", status, 32'h9B);
      chk("R1", "und vector", pc_target, 32'h4);

      for (int n = 0; n < 4000; n++) begin
         r = int'($urandom);
         bits = 0;
         if ((r & 63) == 0) bits |= B_RST;
         if (((r >> 6) & 7) == 0) bits |= B_DABT;
         if (((r >> 9) & 7) == 0) bits |= B_FIQ;
         if (((r >> 12) & 3) == 0) bits |= B_IRQ;
         if (((r >> 14) & 7) == 0) bits |= B_PABT;
         case ((r >> 17) & 15)
            0: bits |= B_UND;
            1: bits |= B_SWI;
            default: ;
         endcase
         if (((r >> 21) & 3) == 0) bits |= B_RET;
         if (((r >> 23) & 7) == 0) bits |= B_WE;
         wd = $urandom;
         wd[4:0] = modes[$urandom_range(5)];
         step(bits, wd, $urandom & 32'hFFFF_FFFC, "");
      end
      summary();
   end

endmodule